// File: doc/BRIEF.md
# Soft-Decision Viterbi Decoder

This block recovers the information bits of a rate-1/2, constraint-length-7 convolutional code. Each trellis step takes a pair of 3-bit soft values, one per coded bit. All 64 states are updated in parallel, so one step completes on every accepted pair. Path metrics are 8 bits wide and are allowed to wrap. Two candidates are compared by the sign of their wrapped difference, so the metrics never need rescaling. Each state keeps a 30-deep history of decisions that is shifted and swapped between states on every step, so no traceback memory is needed.

The upstream stage offers a pair on `in_valid`. The pair is consumed on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low during reset and for the first cycle after it, and then stays high: the decoder never applies back-pressure. The output side has no ready input. A decoded bit appears on `out_bit` with a one-cycle `out_valid` strobe, and the consumer must take it in that cycle. Idle cycles on the input leave the decoder untouched. To flush the last bits of a message, the sender appends 30 pairs carrying encoded zero bits.

Top module: `vit_decoder`

## Requirements
- R1: `in_ready` is 0 while `rst` is high and for the first cycle after it falls, and stays 1 after that. A pair is consumed only on an edge where `in_valid` and `in_ready` are both 1. Cycles with `in_valid` low do not advance the trellis and do not produce output.
- R2: The code has 64 states, rate 1/2 and constraint length 7. Its generators are 133 and 171 (octal). `in_soft_a` carries the output of 133 and `in_soft_b` the output of 171. The most significant tap of each generator applies to the current input bit and the least significant tap to the bit six steps earlier. The encoder starts from the all-zero state. Constant and alternating input streams decode correctly.
- R3: Soft value 0 means a certain 0 and 7 means a certain 1. The cost of a branch is the sum of the distances of the two soft values from the branch's expected bits. Any stream where 0 bits arrive as values 0..3 and 1 bits as values 4..7 decodes without error.
- R4: After reset, the first 30 accepted pairs produce no output. For accepted pair number n with n >= 31, `out_valid` is high for exactly the cycle after that pair's accepting edge. In that cycle `out_bit` is the estimate of input bit number n-30.
- R5: A noiseless random stream of encoded bits decodes with no bit errors.
- R6: A stream where every soft value lies at most 2 levels away from its ideal value (0 or 7) decodes with no bit errors.
- R7: A noisy stream in which one soft value in every 41 steps or more is fully inverted (v becomes 7-v) decodes with no bit errors.
- R8: Reset gives state 0 a metric of 0 and every other state a metric of 32, and clears all histories. A reset in the middle of a stream discards that stream and restarts the R4 count.
- R9: Path metrics wrap modulo 256 without renormalization. Every state's metric stays within 127 above the best metric. A 900-bit noisy stream with idle gaps decodes with no bit errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A soft pair is offered |
| in_ready | output | 1 | Decoder can take a pair (high after reset) |
| in_soft_a | input | 3 | Soft value of the coded bit from generator 133 |
| in_soft_b | input | 3 | Soft value of the coded bit from generator 171 |
| out_valid | output | 1 | One-cycle strobe for a decoded bit |
| out_bit | output | 1 | Decoded information bit |

## Verification
Once the decoder is primed, one edge does two things. It writes new metrics and histories for all 64 states, and it emits a bit taken from the history of the best state, which must be read before that same edge changes it. Back-to-back pairs make these two actions coincide on every edge. Streams with random idle gaps make them fall apart. The decoded sequence is compared bit by bit against input bit n-30 in both cases, so a read of the history after the update, or a step taken on an idle cycle, shows up as a shifted or corrupted sequence.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int CONSTR_LEN = 7;
  localparam int MEM_BITS   = CONSTR_LEN - 1;
  localparam int N_STATES   = 1 << MEM_BITS;
  localparam int SOFT_W     = 3;
  localparam int METRIC_W   = 8;
  localparam int HIST_LEN   = 30;
  localparam logic [METRIC_W-1:0]   START_PENALTY = 8'd32;
  localparam logic [CONSTR_LEN-1:0] POLY_A = 7'o133;
  localparam logic [CONSTR_LEN-1:0] POLY_B = 7'o171;

  // Expected coded pair {a, b} for leaving state st with input in_bit.
  // st[0] is the most recent past input, st[MEM_BITS-1] the oldest.
  function automatic logic [1:0] edge_code(input logic [MEM_BITS-1:0] st,
                                           input logic in_bit);
    logic [CONSTR_LEN-1:0] win;
    win[CONSTR_LEN-1] = in_bit;
    for (int i = 0; i < MEM_BITS; i++) win[CONSTR_LEN-2-i] = st[i];
    return {^(win & POLY_A), ^(win & POLY_B)};
  endfunction
endpackage

// File: rtl/vit_bmu.sv
// Branch costs for the four possible coded pairs; index = {bit_a, bit_b}.
module vit_bmu #(
  parameter int SW = vit_pkg::SOFT_W
) (
  input  logic [SW-1:0]      soft_a,
  input  logic [SW-1:0]      soft_b,
  output logic [3:0][SW:0]   bm
);
  localparam int BW = SW + 1;
  localparam logic [SW-1:0] SURE_ONE = '1;

  for (genvar c = 0; c < 4; c++) begin : g_code
    localparam bit WANT_A = ((c >> 1) & 1) == 1;
    localparam bit WANT_B = (c & 1) == 1;
    logic [SW-1:0] dist_a, dist_b;
    // R3: distance from the expected end of the soft scale
    assign dist_a = WANT_A ? (SURE_ONE - soft_a) : soft_a;
    assign dist_b = WANT_B ? (SURE_ONE - soft_b) : soft_b;
    assign bm[c]  = BW'(dist_a) + BW'(dist_b);
  end
endmodule

// File: rtl/vit_acs_array.sv
// Fully parallel add-compare-select with register-exchange histories.
module vit_acs_array import vit_pkg::*; #(
  parameter int NS    = N_STATES,
  parameter int MW    = METRIC_W,
  parameter int BW    = SOFT_W + 1,
  parameter int DEPTH = HIST_LEN,
  parameter logic [METRIC_W-1:0] PEN = START_PENALTY
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic [3:0][BW-1:0]         bm,
  output logic [NS-1:0][MW-1:0]      pm,
  output logic [NS-1:0][DEPTH-1:0]   surv
);
  localparam int HALF = NS / 2;

  logic [NS-1:0][MW-1:0]    pm_nxt;
  logic [NS-1:0][DEPTH-1:0] surv_nxt;

  // Next state = {old[MEM-2:0], in_bit}; its two predecessors differ in the oldest bit.
  for (genvar s = 0; s < NS; s++) begin : g_acs
    localparam int   P_LO = s / 2;
    localparam int   P_HI = s / 2 + HALF;
    localparam logic DBIT = 1'(s % 2);
    localparam logic [1:0] C_LO = edge_code(MEM_BITS'(P_LO), DBIT);
    localparam logic [1:0] C_HI = edge_code(MEM_BITS'(P_HI), DBIT);

    logic [MW-1:0] cand_lo, cand_hi, diff;
    logic          take_hi;

    assign cand_lo = pm[P_LO] + MW'(bm[C_LO]);
    assign cand_hi = pm[P_HI] + MW'(bm[C_HI]);
    // R9: sign of the wrapped difference decides; ties keep the lower predecessor
    assign diff    = cand_hi - cand_lo;
    assign take_hi = diff[MW-1];

    assign pm_nxt[s]   = take_hi ? cand_hi : cand_lo;
    assign surv_nxt[s] = {take_hi ? surv[P_HI][DEPTH-2:0] : surv[P_LO][DEPTH-2:0], DBIT};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) pm[s] <= (s == 0) ? '0 : PEN;
      surv <= '0;
    end else if (step) begin
      pm   <= pm_nxt;
      surv <= surv_nxt;
    end
  end

  // R8: reset metrics seen in the first cycle after reset
  a_r8_start_metrics: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pm[0] == '0 && pm[NS-1] == PEN && surv == '0));

  // R1: no step, no change to the trellis state
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(pm) && $stable(surv)));
endmodule

// File: rtl/vit_best.sv
// Compare tree that finds the state with the lowest wrapped metric.
module vit_best import vit_pkg::*; #(
  parameter int NS = N_STATES,
  parameter int MW = METRIC_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NS-1:0][MW-1:0]    pm,
  output logic [$clog2(NS)-1:0]    best_idx
);
  localparam int IW = $clog2(NS);
  localparam int HALF_RANGE = 1 << (MW - 1);

  logic [MW-1:0] node_m [NS];
  logic [IW-1:0] node_i [NS];
  logic [MW-1:0] best_pm;

  always_comb begin
    logic [MW-1:0] d;
    d = '0;
    for (int i = 0; i < NS; i++) begin
      node_m[i] = pm[i];
      node_i[i] = IW'(i);
    end
    for (int w = NS / 2; w >= 1; w = w / 2) begin
      for (int i = 0; i < w; i++) begin
        d = node_m[2*i+1] - node_m[2*i];
        if (d[MW-1]) begin
          node_m[i] = node_m[2*i+1];
          node_i[i] = node_i[2*i+1];
        end else begin
          node_m[i] = node_m[2*i];
          node_i[i] = node_i[2*i];
        end
      end
    end
  end

  assign best_idx = node_i[0];
  assign best_pm  = node_m[0];

  // R9: every metric lies within half the wrap range above the winner
  for (genvar s = 0; s < NS; s++) begin : g_spread
    a_r9_metric_spread: assert property (@(posedge clk) disable iff (rst)
      (32'(MW'(pm[s] - best_pm)) < HALF_RANGE));
  end
endmodule

// File: rtl/vit_decoder.sv
module vit_decoder import vit_pkg::*; #(
  parameter int SW    = SOFT_W,
  parameter int MW    = METRIC_W,
  parameter int DEPTH = HIST_LEN,
  parameter int NS    = N_STATES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_soft_a,
  input  logic [SW-1:0] in_soft_b,
  output logic          out_valid,
  output logic          out_bit
);
  localparam int BW = SW + 1;
  localparam int IW = $clog2(NS);
  localparam int FW = $clog2(DEPTH + 1);

  logic                     step;
  logic [3:0][BW-1:0]       bm;
  logic [NS-1:0][MW-1:0]    pm;
  logic [NS-1:0][DEPTH-1:0] surv;
  logic [IW-1:0]            best_idx;
  logic [FW-1:0]            fill;

  assign step = in_valid & in_ready;

  vit_bmu #(.SW(SW)) u_bmu (
    .soft_a (in_soft_a),
    .soft_b (in_soft_b),
    .bm     (bm)
  );

  vit_acs_array #(.NS(NS), .MW(MW), .BW(BW), .DEPTH(DEPTH)) u_acs (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .bm   (bm),
    .pm   (pm),
    .surv (surv)
  );

  vit_best #(.NS(NS), .MW(MW)) u_best (
    .clk      (clk),
    .rst      (rst),
    .pm       (pm),
    .best_idx (best_idx)
  );

  // Output reads the registered history, i.e. the one before this step's update.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready  <= 1'b0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= 1'b0;
      if (step) begin
        if (fill == FW'(DEPTH)) begin
          out_valid <= 1'b1;
          out_bit   <= surv[best_idx][DEPTH-1];
        end else begin
          fill <= fill + 1'b1;
        end
      end
    end
  end

  // R1: ready is low after a reset cycle
  a_r1_ready_low_in_reset: assert property (@(posedge clk)
    rst |=> !in_ready);

  // R1: once raised, ready stays up until the next reset
  a_r1_ready_hold: assert property (@(posedge clk) disable iff (rst)
    $past(in_ready) |-> in_ready);

  // R4: a strobe always follows an accepting edge
  a_r4_out_after_accept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready));

  // R4: no strobe before the history is full
  a_r4_out_only_primed: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fill == FW'(DEPTH)));
endmodule

// File: tb/vit_decoder_bench.sv
`timescale 1ns/1ps
module vit_decoder_bench;
  localparam int DEPTH = 30;
  localparam logic [6:0] GA = 7'o133;
  localparam logic [6:0] GB = 7'o171;
  localparam int MAXB = 2048;

  typedef struct packed {
    logic [10:0] len;
    logic [1:0]  amp;
    logic [7:0]  flip;
    logic        gap;
    logic        pre;
    logic [1:0]  pat;
    logic [31:0] seed;
    logic [10:0] expect_n;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  // pat: 0 random, 1 all ones, 2 alternating
  localparam vec_t VECS [NV] = '{
    '{len:11'd200, amp:2'd0, flip:8'd0,  gap:1'b0, pre:1'b0, pat:2'd0, seed:32'h1234_5678, expect_n:11'd200, req:4'd5}, // R5
    '{len:11'd300, amp:2'd2, flip:8'd0,  gap:1'b0, pre:1'b0, pat:2'd0, seed:32'h0BAD_F00D, expect_n:11'd300, req:4'd6}, // R6
    '{len:11'd250, amp:2'd3, flip:8'd0,  gap:1'b0, pre:1'b0, pat:2'd0, seed:32'h7777_1111, expect_n:11'd250, req:4'd3}, // R3
    '{len:11'd400, amp:2'd2, flip:8'd41, gap:1'b0, pre:1'b0, pat:2'd0, seed:32'hC0FF_EE01, expect_n:11'd400, req:4'd7}, // R7
    '{len:11'd250, amp:2'd1, flip:8'd0,  gap:1'b1, pre:1'b0, pat:2'd0, seed:32'h2468_ACE0, expect_n:11'd250, req:4'd1}, // R1
    '{len:11'd150, amp:2'd1, flip:8'd0,  gap:1'b0, pre:1'b1, pat:2'd0, seed:32'h1357_9BDF, expect_n:11'd150, req:4'd8}, // R8
    '{len:11'd900, amp:2'd2, flip:8'd53, gap:1'b1, pre:1'b0, pat:2'd0, seed:32'hDEAD_BEEF, expect_n:11'd900, req:4'd9}, // R9
    '{len:11'd120, amp:2'd0, flip:8'd0,  gap:1'b0, pre:1'b0, pat:2'd1, seed:32'h0000_0101, expect_n:11'd120, req:4'd2}, // R2
    '{len:11'd120, amp:2'd0, flip:8'd0,  gap:1'b0, pre:1'b0, pat:2'd2, seed:32'h0000_0202, expect_n:11'd120, req:4'd2}  // R2
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_soft_a = '0;
  logic [2:0] in_soft_b = '0;
  logic       out_valid;
  logic       out_bit;

  int errs = 0;
  int checks = 0;
  int n_rx = 0;
  int rx_bad = 0;
  logic        sent [MAXB];
  logic [6:0]  hist = '0;
  logic [31:0] rs = 32'h1;

  always #10 clk = ~clk;

  vit_decoder u_vit_decoder (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_soft_a (in_soft_a),
    .in_soft_b (in_soft_b),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (n_rx < MAXB && out_bit !== sent[n_rx]) rx_bad++;
      n_rx++;
    end
  end

  function automatic logic [31:0] nxt();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  // h[d] is the input bit d steps ago; generator bit (6-d) multiplies it
  function automatic logic [1:0] enc(input logic [6:0] h);
    logic a, b;
    a = 1'b0; b = 1'b0;
    for (int d = 0; d < 7; d++) begin
      if (GA[6-d]) a ^= h[d];
      if (GB[6-d]) b ^= h[d];
    end
    return {a, b};
  endfunction

  function automatic logic [2:0] soft_of(input logic b, input int amp);
    int n;
    n = (amp == 0) ? 0 : int'(nxt() % 32'(amp + 1));
    return b ? 3'(7 - n) : 3'(n);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] a, input logic [2:0] b);
    in_valid  = 1'b1;
    in_soft_a = a;
    in_soft_b = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_bit(input logic b, input int amp, input bit flip);
    logic [1:0] c;
    logic [2:0] sa, sb;
    hist = {hist[5:0], b};
    c  = enc(hist);
    sa = soft_of(c[1], amp);
    sb = soft_of(c[0], amp);
    if (flip) sa = 3'd7 - sa;
    push(sa, sb);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_rx = 0;
    rx_bad = 0;
    hist = '0;
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    int total;
    logic b;
    logic [31:0] r;
    tag = $sformatf("R%0d", v.req);
    rs = v.seed;
    if (v.pre) begin
      // R8: garbage stream interrupted by reset
      for (int k = 0; k < 25; k++) begin
        r = nxt();
        push(r[2:0], r[5:3]);
      end
    end
    do_reset();
    total = int'(v.len) + DEPTH;
    for (int k = 0; k < total; k++) begin
      if (k >= int'(v.len)) b = 1'b0;
      else if (v.pat == 2'd1) b = 1'b1;
      else if (v.pat == 2'd2) b = k[0];
      else begin
        r = nxt();
        b = r[0];
      end
      sent[k] = b;
      send_bit(b, int'(v.amp), (v.flip != 0) && ((k % int'(v.flip)) == int'(v.flip) - 1));
      if (v.gap) begin
        r = nxt();
        if (r[1:0] == 2'b00) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    check(n_rx == int'(v.expect_n), tag, "output count", n_rx, v.expect_n);
    check(rx_bad == 0, tag, "decoded bit errors", rx_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    // R1 / R4: reset state
    repeat (3) @(negedge clk);
    check(in_ready === 1'b0, "R1", "in_ready during reset", in_ready, 0);
    check(out_valid === 1'b0, "R4", "out_valid during reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R4: priming latency and the exact strobe cycle
    do_reset();
    rs = 32'h5EED_0004;
    for (int k = 0; k < DEPTH + 1; k++) begin
      r = nxt();
      sent[k] = r[0];
      send_bit(r[0], 0, 1'b0);
      if (k == DEPTH - 1)
        check(n_rx == 0, "R4", "strobes during first 30 pairs", n_rx, 0);
    end
    check(out_valid === 1'b1, "R4", "strobe after pair 31", out_valid, 1);
    check(out_bit === sent[0], "R4", "first decoded bit", out_bit, sent[0]);
    @(negedge clk);
    check(out_valid === 1'b0, "R4", "strobe lasts one cycle", out_valid, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule